// File: doc/BRIEF.md
# PCI Bus Arbiter with Parking

This block is the central arbiter of one PCI segment. It takes the requests of the host and of a set of slot agents and decides which single agent owns the bus next. Requests and grants are active low. The block watches the FRAME# and IRDY# lines to tell when the bus is idle. A static configuration word sets which slots may compete, where the bus parks when nobody asks for it, and whether one agent gets a guaranteed turn on every other arbitration decision.

Agents are numbered from 0. Index 0 is the host and index k (1..N_SLOTS) is slot k. Request bit k and grant bit k belong to agent k. Enable bit k-1 and favour bit k-1 belong to slot k. An arbitration decision is made in any cycle where an agent holds the grant and either the bus is idle or that agent has no eligible request. When the decision names a different agent, the grant is withdrawn for one clock and then given to the new agent.

Top module: `pci_bus_arbiter`

## Requirements
- R1: During and right after reset, the host (grant bit 0) holds the grant and every slot grant is deasserted.
- R2: No more than one grant line is low in any cycle.
- R3: A slot whose enable bit (cfg_slot_en[k-1] for slot k) is 0 is treated as not requesting. If it stays disabled for two consecutive cycles, it cannot gain the grant.
- R4: When the grant passes from one agent to another, there is exactly one clock with all grant lines high between the two owners.
- R5: While the bus is busy (FRAME# or IRDY# low) and the owner keeps an eligible request, the grant does not move. When the owner drops its request, the grant is withdrawn even if the bus is busy.
- R6: With no eligible request and cfg_park_prev = 0, the bus is parked on the host.
- R7: With no eligible request and cfg_park_prev = 1, the bus stays parked on the last agent that won a request. If that agent is a slot that is now disabled, it parks on the host instead.
- R8: With cfg_host_fav = 1, the host wins every other decision while it requests. The decisions in between go to the other requesters.
- R9: A nonzero cfg_fav_slot names the favoured slot by its lowest set bit (bit k-1 names slot k). That slot wins every other decision while it requests.
- R10: If cfg_host_fav and cfg_fav_slot are both set, the host is the favoured agent and the named slot competes as an ordinary requester.
- R11: The requesters that are not favoured are served round-robin in ascending index order, wrapping from N_SLOTS to 0. The search starts just after the agent of the last round-robin win. A favoured agent that requests alone is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | N_SLOTS+1 | Active-low requests, bit 0 host, bit k slot k |
| frame_n | input | 1 | Bus FRAME#, low while a transaction is in progress |
| irdy_n | input | 1 | Bus IRDY#, low while the initiator is driving a data phase |
| cfg_slot_en | input | N_SLOTS | Per-slot arbitration enables, bit k-1 for slot k |
| cfg_park_prev | input | 1 | 0: park on host, 1: park on last winner |
| cfg_host_fav | input | 1 | Host wins every other decision |
| cfg_fav_slot | input | N_SLOTS | Favoured slot, lowest set bit counts |
| gnt_n | output | N_SLOTS+1 | Active-low grants, bit 0 host, bit k slot k |

## Verification
Two functions can fall in the same cycle. The favoured-agent alternation and the round-robin rotation can both claim a decision. The owner dropping its request can also coincide with other agents arriving while the bus is busy. The bench provokes the first with every agent requesting on an idle bus, under each favour setting. It then checks the compressed order of owners against sequences worked out by hand. A sweep over all 1024 configurations with pseudo-random requests and bus activity compares every cycle's grant vector with an arithmetic model of the rules, so simultaneous drops, arrivals and disables are judged cycle by cycle.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

   // Grant phase: an owner holds the grant, or the bus is in the dead clock
   typedef enum logic {
      PH_OWN = 1'b0,
      PH_GAP = 1'b1
   } arb_phase_e;

   localparam int MAX_SLOTS = 15;

endpackage

// File: rtl/pci_arb_elig.sv
module pci_arb_elig #(
   parameter int N_AG = 5
) (
   input  logic [N_AG-1:0] req_n,
   input  logic [N_AG-2:0] slot_en,
   input  logic            frame_n,
   input  logic            irdy_n,
   output logic [N_AG-1:0] elig,
   output logic            bus_idle
);

   assign elig[0]  = ~req_n[0];
   assign bus_idle = frame_n & irdy_n;

   for (genvar s = 0; s < N_AG-1; s++) begin : g_slot
      assign elig[s+1] = ~req_n[s+1] & slot_en[s];
   end

endmodule

// File: rtl/pci_arb_pick.sv
module pci_arb_pick #(
   parameter int N_AG          = 5,
   parameter int IW            = 3,
   parameter bit HOST_FAV_WINS = 1'b1
) (
   input  logic [N_AG-1:0] elig,
   input  logic [N_AG-2:0] slot_en,
   input  logic            host_fav,
   input  logic [N_AG-2:0] fav_mask,
   input  logic            park_prev,
   input  logic [IW-1:0]   prev_own,
   input  logic [IW-1:0]   rr_ptr,
   input  logic            fav_due,
   output logic [IW-1:0]   win,
   output logic            any_req,
   output logic            by_rr,
   output logic            fav_win
);

   logic            slot_fav_v;
   logic [IW-1:0]   slot_fav_idx;
   logic            fav_v;
   logic [IW-1:0]   fav_idx;
   logic [N_AG-1:0] fav_bit;
   logic [N_AG-1:0] others;
   logic [IW-1:0]   rr_idx;
   logic            rr_found;
   logic            prev_ok;
   logic [IW-1:0]   park_idx;

   // lowest set bit of the favour mask names the slot
   always_comb begin
      slot_fav_v   = 1'b0;
      slot_fav_idx = '0;
      for (int i = N_AG-2; i >= 0; i--) begin
         if (fav_mask[i]) begin
            slot_fav_v   = 1'b1;
            slot_fav_idx = IW'(i+1);
         end
      end
   end

   if (HOST_FAV_WINS) begin : g_host_first
      assign fav_v   = host_fav | slot_fav_v;
      assign fav_idx = host_fav ? '0 : slot_fav_idx;
   end else begin : g_slot_first
      assign fav_v   = host_fav | slot_fav_v;
      assign fav_idx = slot_fav_v ? slot_fav_idx : '0;
   end

   always_comb begin
      fav_bit = '0;
      if (fav_v) fav_bit[fav_idx] = 1'b1;
   end

   assign others  = elig & ~fav_bit;
   assign any_req = |elig;

   // rotating search starting one past the round-robin pointer
   always_comb begin
      rr_found = 1'b0;
      rr_idx   = '0;
      for (int off = 1; off <= N_AG; off++) begin
         int c;
         c = int'(rr_ptr) + off;
         if (c >= N_AG) c = c - N_AG;
         if (!rr_found && others[c]) begin
            rr_found = 1'b1;
            rr_idx   = IW'(c);
         end
      end
   end

   always_comb begin
      prev_ok = (prev_own == '0);
      for (int i = 0; i < N_AG-1; i++) begin
         if (prev_own == IW'(i+1) && slot_en[i]) prev_ok = 1'b1;
      end
   end

   assign park_idx = (park_prev && prev_ok) ? prev_own : '0;

   assign fav_win = fav_v && elig[fav_idx] && (fav_due || (others == '0));
   assign by_rr   = any_req && !fav_win;

   always_comb begin
      if (fav_win)       win = fav_idx;
      else if (any_req)  win = rr_idx;
      else               win = park_idx;
   end

   // the chosen agent must actually be requesting when anyone is (R11)
   always_comb begin
      if (any_req) begin
         a_win_requests_r11 : assert (elig[win] || $isunknown(elig));
      end
   end

endmodule

// File: rtl/pci_bus_arbiter.sv
module pci_bus_arbiter #(
   parameter int N_SLOTS       = 4,
   parameter bit HOST_FAV_WINS = 1'b1,
   localparam int N_AG         = N_SLOTS + 1,
   localparam int IW           = (N_AG > 1) ? $clog2(N_AG) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_AG-1:0]    req_n,
   input  logic               frame_n,
   input  logic               irdy_n,
   input  logic [N_SLOTS-1:0] cfg_slot_en,
   input  logic               cfg_park_prev,
   input  logic               cfg_host_fav,
   input  logic [N_SLOTS-1:0] cfg_fav_slot,
   output logic [N_AG-1:0]    gnt_n
);
   import pci_arb_pkg::*;

   if (N_SLOTS < 1 || N_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("pci_bus_arbiter: N_SLOTS out of range");
   end

   arb_phase_e      phase;
   logic [IW-1:0]   cur;
   logic [IW-1:0]   pend;
   logic [IW-1:0]   prev_own;
   logic [IW-1:0]   rr_ptr;
   logic            fav_due;

   logic [N_AG-1:0] elig;
   logic            bus_idle;
   logic [IW-1:0]   win;
   logic            any_req;
   logic            by_rr;
   logic            fav_win;
   logic            decide;

   pci_arb_elig #(.N_AG(N_AG)) u_elig (
      .req_n    (req_n),
      .slot_en  (cfg_slot_en),
      .frame_n  (frame_n),
      .irdy_n   (irdy_n),
      .elig     (elig),
      .bus_idle (bus_idle)
   );

   pci_arb_pick #(.N_AG(N_AG), .IW(IW), .HOST_FAV_WINS(HOST_FAV_WINS)) u_pick (
      .elig      (elig),
      .slot_en   (cfg_slot_en),
      .host_fav  (cfg_host_fav),
      .fav_mask  (cfg_fav_slot),
      .park_prev (cfg_park_prev),
      .prev_own  (prev_own),
      .rr_ptr    (rr_ptr),
      .fav_due   (fav_due),
      .win       (win),
      .any_req   (any_req),
      .by_rr     (by_rr),
      .fav_win   (fav_win)
   );

   assign decide = (phase == PH_OWN) && (bus_idle || !elig[cur]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_OWN;
         cur      <= '0;
         pend     <= '0;
         prev_own <= '0;
         rr_ptr   <= '0;
         fav_due  <= 1'b1;
      end else if (phase == PH_GAP) begin
         phase <= PH_OWN;
         cur   <= pend;
      end else if (decide) begin
         if (any_req) begin
            prev_own <= win;
            fav_due  <= !fav_win;
            if (by_rr) rr_ptr <= win;
         end
         if (win != cur) begin
            phase <= PH_GAP;
            pend  <= win;
         end
      end
   end

   for (genvar k = 0; k < N_AG; k++) begin : g_gnt
      assign gnt_n[k] = !((phase == PH_OWN) && (cur == IW'(k)));

      p_gap_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         !gnt_n[k] |=> (!gnt_n[k] || (&gnt_n)));

      p_busy_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
         (!gnt_n[k] && !(frame_n && irdy_n) && elig[k]) |=> !gnt_n[k]);
   end

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_dis
      p_disabled_r3 : assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_slot_en[s] && $past(!cfg_slot_en[s])) |=> gnt_n[s+1]);
   end

   p_one_grant_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~gnt_n) <= 1);

   p_reset_host_r1 : assert property (@(posedge clk)
      !rst_n |=> (gnt_n == {{N_SLOTS{1'b1}}, 1'b0}));

endmodule

// File: tb/pci_bus_arbiter_tb.sv
module pci_bus_arbiter_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] req_n = 5'h1f;
   logic       frame_n = 1'b1;
   logic       irdy_n = 1'b1;
   logic [3:0] cfg_slot_en = 4'hf;
   logic       cfg_park_prev = 1'b0;
   logic       cfg_host_fav = 1'b0;
   logic [3:0] cfg_fav_slot = 4'h0;
   logic [4:0] gnt_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pci_bus_arbiter u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_n         (req_n),
      .frame_n       (frame_n),
      .irdy_n        (irdy_n),
      .cfg_slot_en   (cfg_slot_en),
      .cfg_park_prev (cfg_park_prev),
      .cfg_host_fav  (cfg_host_fav),
      .cfg_fav_slot  (cfg_fav_slot),
      .gnt_n         (gnt_n)
   );

   // reference model of the requirements
   bit m_gap;
   int m_cur, m_pend, m_prev, m_rr;
   bit m_due;

   task automatic m_reset();
      m_gap = 0; m_cur = 0; m_pend = 0; m_prev = 0; m_rr = 0; m_due = 1;
   endtask

   function automatic int fav_agent();
      if (cfg_host_fav) return 0;
      for (int i = 0; i < 4; i++) if (cfg_fav_slot[i]) return i + 1;
      return -1;
   endfunction

   task automatic m_step();
      bit [4:0] el;
      bit [4:0] oth;
      bit idle;
      int fv, w;
      bit hit;
      el[0] = !req_n[0];
      for (int i = 1; i < 5; i++) el[i] = !req_n[i] && cfg_slot_en[i-1];
      idle = frame_n && irdy_n;
      if (m_gap) begin
         m_gap = 0; m_cur = m_pend;
         return;
      end
      if (!idle && el[m_cur]) return;
      fv = fav_agent();
      if (el == 0) begin
         if (cfg_park_prev && (m_prev == 0 || cfg_slot_en[m_prev-1])) w = m_prev;
         else w = 0;
      end else begin
         oth = el;
         if (fv >= 0) oth[fv] = 1'b0;
         if (fv >= 0 && el[fv] && (m_due || oth == 0)) begin
            w = fv; m_due = 0;
         end else begin
            hit = 0; w = 0;
            for (int s = 1; s <= 5; s++) begin
               if (!hit && oth[(m_rr + s) % 5]) begin
                  hit = 1; w = (m_rr + s) % 5;
               end
            end
            m_rr = w; m_due = 1;
         end
         m_prev = w;
      end
      if (w != m_cur) begin
         m_gap = 1; m_pend = w;
      end
   endtask

   function automatic logic [4:0] m_gnt();
      if (m_gap) return 5'h1f;
      return ~(5'b1 << m_cur);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: gnt_n=%b expected %b", req, act, exp);
      end
   endtask

   task automatic chk_g(input string req, input logic [4:0] exp);
      chk(gnt_n === exp, req, gnt_n, exp);
   endtask

   // inputs are set at a falling edge; one rising edge; back at a falling edge
   task automatic tick();
      m_step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      m_reset();
      rst_n = 1'b1;
   endtask

   function automatic logic [4:0] g1(input int a);
      return ~(5'b1 << a);
   endfunction

   // all agents request on an idle bus; compressed owner order compared
   task automatic seq_check(input string req, input int exp [10]);
      int got [10];
      int cnt;
      int idx;
      req_n = 5'h00; frame_n = 1'b1; irdy_n = 1'b1;
      do_reset();
      cnt = 0;
      for (int t = 0; t < 40; t++) begin
         if (gnt_n != 5'h1f) begin
            idx = 0;
            for (int i = 0; i < 5; i++) if (!gnt_n[i]) idx = i;
            if (cnt < 10 && (cnt == 0 || got[cnt-1] != idx)) begin
               got[cnt] = idx; cnt++;
            end
         end
         tick();
      end
      for (int i = 0; i < 10; i++) begin
         n_chk++;
         if (i >= cnt || got[i] != exp[i]) begin
            n_fail++;
            $display("FAIL %s: owner #%0d is %0d expected %0d", req, i, (i < cnt) ? got[i] : -1, exp[i]);
         end
      end
   endtask

   initial begin
      logic [15:0] lf;
      int seq_rr [10]   = '{0, 1, 2, 3, 4, 0, 1, 2, 3, 4};
      int seq_host [10] = '{0, 1, 0, 2, 0, 3, 0, 4, 0, 1};
      int seq_s3 [10]   = '{0, 3, 1, 3, 2, 3, 4, 3, 0, 3};
      int seq_s2 [10]   = '{0, 2, 1, 2, 3, 2, 4, 2, 0, 2};

      @(negedge clk);
      do_reset();
      // R1: host parked after reset
      chk_g("R1", 5'b11110);

      // R6: slot 2 wins, then releases; park on host
      req_n = 5'b11011;
      tick(); chk_g("R4", 5'h1f);
      tick(); chk_g("R11", g1(2));
      req_n = 5'h1f;
      tick(); chk_g("R4", 5'h1f);
      tick(); chk_g("R6", g1(0));

      // R7: park on previous owner, fall back to host when it is disabled
      cfg_park_prev = 1'b1;
      do_reset();
      req_n = 5'b11011;
      tick(); tick(); chk_g("R7", g1(2));
      req_n = 5'h1f;
      for (int i = 0; i < 3; i++) begin
         tick(); chk_g("R7", g1(2));
      end
      cfg_slot_en = 4'b1101;
      tick(); chk_g("R7", 5'h1f);
      tick(); chk_g("R7", g1(0));
      cfg_slot_en = 4'hf; cfg_park_prev = 1'b0;

      // R5: owner kept while busy, withdrawn when it drops its request
      do_reset();
      req_n = 5'b11101;
      tick(); tick(); chk_g("R5", g1(1));
      frame_n = 1'b0; req_n = 5'b10101;
      for (int i = 0; i < 3; i++) begin
         tick(); chk_g("R5", g1(1));
      end
      req_n = 5'b10111;
      tick(); chk_g("R5", 5'h1f);
      tick(); chk_g("R5", g1(3));
      frame_n = 1'b1; req_n = 5'h1f;

      // R3: disabled slot request ignored
      cfg_slot_en = 4'b1110;
      do_reset();
      req_n = 5'b11101;
      for (int i = 0; i < 4; i++) begin
         tick(); chk_g("R3", g1(0));
      end
      cfg_slot_en = 4'hf; req_n = 5'h1f;

      // rotation and favour orders
      cfg_host_fav = 1'b0; cfg_fav_slot = 4'b0000;
      seq_check("R11", seq_rr);
      cfg_host_fav = 1'b1;
      seq_check("R8", seq_host);
      cfg_host_fav = 1'b0; cfg_fav_slot = 4'b0100;
      seq_check("R9", seq_s3);
      cfg_fav_slot = 4'b0110;
      seq_check("R9", seq_s2);
      cfg_host_fav = 1'b1; cfg_fav_slot = 4'b0100;
      seq_check("R10", seq_host);

      // sweep every configuration with pseudo-random traffic
      lf = 16'hace1;
      for (int c = 0; c < 1024; c++) begin
         cfg_slot_en   = c[3:0];
         cfg_fav_slot  = c[7:4];
         cfg_park_prev = c[8];
         cfg_host_fav  = c[9];
         req_n = 5'h1f; frame_n = 1'b1; irdy_n = 1'b1;
         do_reset();
         for (int t = 0; t < 30; t++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            req_n   = req_n ^ (lf[4:0] & lf[9:5]);
            frame_n = lf[10] | lf[11];
            irdy_n  = lf[12] | lf[13];
            tick();
            chk(gnt_n === m_gnt(), "R11", gnt_n, m_gnt());
            chk($countones(~gnt_n) <= 1, "R2", gnt_n, m_gnt());
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule